// File: doc/BRIEF.md
# Microcoded Multi-Cycle Control Sequencer

This block produces the per-cycle control bundle of a multi-cycle processor datapath. It does so from a small constant micro-instruction store rather than from a hand-coded state machine. A micro-address register selects one micro-word per clock. Each word has two parts: a control part, which drives the datapath outputs for that one cycle, and a 2-bit sequencing part, which tells the address selector how to form the next micro-address.

The next micro-address comes from one of four sources: the current address plus one, a restart at the fetch word, a first dispatch table, or a second dispatch table. The first table is indexed by the 6-bit opcode at the end of decode. The second is indexed by the opcode after the memory-address word and separates loads from stores.

The store is read synchronously at the next address, so the control outputs come straight from a register. The outputs still match cycle for cycle what a hardwired controller with one state per micro-word would drive. The opcode input is the opcode field of the instruction register and must stay stable for the whole instruction.

Top module: `ucode_sequencer`

## Requirements
- R1: While `rst` is high, from the first clock edge onward, the outputs carry the fetch word. In the first cycle after `rst` falls, the outputs also carry the fetch word.
- R2: The fetch word drives `pc_wr`=1, `mem_rd`=1, `ir_wr`=1, `alu_b_sel`=01, and 0 on every other output.
- R3: The decode word drives `alu_b_sel`=11, and 0 on every other output. This includes `alu_a_sel`=0 and `alu_op`=00.
- R4: After decode, the next word depends on the opcode: 0x00 (register op) goes to execute, 0x23 (load) and 0x2B (store) go to address calculation, 0x04 (branch) goes to branch, and 0x02 (jump) goes to jump.
- R5: After address calculation, opcode 0x23 goes to memory read and 0x2B goes to memory write.
- R6: Three transitions use the incremented address: fetch to decode, memory read to load write-back, and execute to register write-back.
- R7: Load write-back, memory write, register write-back, branch and jump each return to fetch. Instruction lengths in cycles are therefore: load 5, store 4, register op 4, branch 3, jump 3.
- R8: An opcode not listed in R4 runs fetch, then decode, then fetch again, for a length of 2 cycles.
- R9: `mem_rd` and `mem_wr` are never high together. `pc_wr` and `pc_wr_cond` are never high together.
- R10: Each remaining word drives 0 on every output except those listed for it:
  - address calculation: `alu_a_sel`=1, `alu_b_sel`=10
  - memory read: `mem_rd`=1, `addr_data`=1
  - load write-back: `rf_wr`=1, `wb_from_mem`=1
  - memory write: `mem_wr`=1, `addr_data`=1
  - execute: `alu_a_sel`=1, `alu_op`=10
  - register write-back: `rf_wr`=1, `rf_dst_rd`=1
  - branch: `pc_wr_cond`=1, `pc_src`=01, `alu_a_sel`=1, `alu_op`=01
  - jump: `pc_wr`=1, `pc_src`=10

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the instruction register |
| pc_wr | output | 1 | Unconditional program counter write |
| pc_wr_cond | output | 1 | Program counter write if the compare is zero |
| pc_src | output | 2 | Program counter source: 00 ALU, 01 ALU register, 10 jump target |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| addr_data | output | 1 | Memory address from the ALU register (1) or the program counter (0) |
| ir_wr | output | 1 | Instruction register load |
| alu_a_sel | output | 1 | ALU A from register A (1) or the program counter (0) |
| alu_b_sel | output | 2 | ALU B: 00 register B, 01 constant 4, 10 immediate, 11 shifted immediate |
| alu_op | output | 2 | ALU operation class: 00 add, 01 subtract, 10 function field |
| rf_wr | output | 1 | Register file write |
| rf_dst_rd | output | 1 | Destination is the rd field (1) or the rt field (0) |
| wb_from_mem | output | 1 | Write-back data from memory (1) or the ALU (0) |

## Verification
The bench runs a one-state-per-word hardwired reference next to the block and sweeps all 64 opcodes, in ascending order and then descending. It compares the full bundle on every cycle and checks the length of each instruction. The sweep catches three kinds of dispatch error: a table entry that is wrong, a default entry that is wrong, or a second-table entry that swaps load and store. Each of these leaves the control sequence on the wrong word and gives the wrong instruction length. An increment that is off, or a terminal word that fails to restart, shows up as extra or missing cycles before the next fetch. A reset applied in the middle of a load must return the block to the fetch word at once; a design that misses this would keep driving load control.

// File: rtl/ucode_pkg.sv
package ucode_pkg;

  typedef struct packed {
    logic       pc_wr;
    logic       pc_wr_cond;
    logic [1:0] pc_src;
    logic       mem_rd;
    logic       mem_wr;
    logic       addr_data;
    logic       ir_wr;
    logic       alu_a_sel;
    logic [1:0] alu_b_sel;
    logic [1:0] alu_op;
    logic       rf_wr;
    logic       rf_dst_rd;
    logic       wb_from_mem;
  } ctrl_t;

  typedef enum logic [1:0] {
    SEQ_FETCH = 2'b00,
    SEQ_DISP1 = 2'b01,
    SEQ_DISP2 = 2'b10,
    SEQ_NEXT  = 2'b11
  } seq_t;

  typedef struct packed {
    ctrl_t ctrl;
    seq_t  seq;
  } uword_t;

  localparam int UA_FETCH  = 0;
  localparam int UA_DECODE = 1;
  localparam int UA_MADDR  = 2;
  localparam int UA_MRD    = 3;
  localparam int UA_MWB    = 4;
  localparam int UA_MWR    = 5;
  localparam int UA_EXEC   = 6;
  localparam int UA_RDONE  = 7;
  localparam int UA_BR     = 8;
  localparam int UA_JMP    = 9;
  localparam int UA_USED   = 10;

  localparam logic [5:0] OP_REG   = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_BRANCH = 6'h04;
  localparam logic [5:0] OP_JUMP  = 6'h02;

  // Microprogram contents; unused addresses hold an idle word that restarts.
  function automatic uword_t ucode_word(input int a);
    uword_t w;
    w = '0;
    case (a)
      UA_FETCH: begin
        w.ctrl.pc_wr = 1'b1; w.ctrl.mem_rd = 1'b1; w.ctrl.ir_wr = 1'b1;
        w.ctrl.alu_b_sel = 2'b01; w.seq = SEQ_NEXT;
      end
      UA_DECODE: begin
        w.ctrl.alu_b_sel = 2'b11; w.seq = SEQ_DISP1;
      end
      UA_MADDR: begin
        w.ctrl.alu_a_sel = 1'b1; w.ctrl.alu_b_sel = 2'b10; w.seq = SEQ_DISP2;
      end
      UA_MRD: begin
        w.ctrl.mem_rd = 1'b1; w.ctrl.addr_data = 1'b1; w.seq = SEQ_NEXT;
      end
      UA_MWB: begin
        w.ctrl.rf_wr = 1'b1; w.ctrl.wb_from_mem = 1'b1; w.seq = SEQ_FETCH;
      end
      UA_MWR: begin
        w.ctrl.mem_wr = 1'b1; w.ctrl.addr_data = 1'b1; w.seq = SEQ_FETCH;
      end
      UA_EXEC: begin
        w.ctrl.alu_a_sel = 1'b1; w.ctrl.alu_op = 2'b10; w.seq = SEQ_NEXT;
      end
      UA_RDONE: begin
        w.ctrl.rf_wr = 1'b1; w.ctrl.rf_dst_rd = 1'b1; w.seq = SEQ_FETCH;
      end
      UA_BR: begin
        w.ctrl.pc_wr_cond = 1'b1; w.ctrl.pc_src = 2'b01;
        w.ctrl.alu_a_sel = 1'b1; w.ctrl.alu_op = 2'b01; w.seq = SEQ_FETCH;
      end
      UA_JMP: begin
        w.ctrl.pc_wr = 1'b1; w.ctrl.pc_src = 2'b10; w.seq = SEQ_FETCH;
      end
      default: w.seq = SEQ_FETCH;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/ucode_rom.sv
module ucode_rom
  import ucode_pkg::*;
#(
  parameter int UA_W = 4
) (
  input  logic            clk,
  input  logic [UA_W-1:0] rd_addr,
  output uword_t          word_q
);
  localparam int DEPTH = 2 ** UA_W;

  uword_t mem [DEPTH];

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_word
      assign mem[g] = ucode_word(g);
    end
  endgenerate

  // Synchronous read: the word for the next address lands in the output register.
  always_ff @(posedge clk) begin
    word_q <= mem[rd_addr];
  end
endmodule

// File: rtl/ucode_dispatch.sv
module ucode_dispatch
  import ucode_pkg::*;
#(
  parameter int OPC_W = 6,
  parameter int UA_W  = 4
) (
  input  logic [OPC_W-1:0] opcode,
  output logic [UA_W-1:0]  disp1,
  output logic [UA_W-1:0]  disp2
);
  // Table used after decode.
  always_comb begin
    case (opcode)
      OPC_W'(OP_REG):    disp1 = UA_W'(UA_EXEC);
      OPC_W'(OP_LOAD):   disp1 = UA_W'(UA_MADDR);
      OPC_W'(OP_STORE):  disp1 = UA_W'(UA_MADDR);
      OPC_W'(OP_BRANCH): disp1 = UA_W'(UA_BR);
      OPC_W'(OP_JUMP):   disp1 = UA_W'(UA_JMP);
      default:           disp1 = UA_W'(UA_FETCH);
    endcase
  end

  // Table used after address calculation: load versus store.
  always_comb begin
    case (opcode)
      OPC_W'(OP_LOAD):  disp2 = UA_W'(UA_MRD);
      OPC_W'(OP_STORE): disp2 = UA_W'(UA_MWR);
      default:          disp2 = UA_W'(UA_FETCH);
    endcase
  end
endmodule

// File: rtl/ucode_next.sv
module ucode_next
  import ucode_pkg::*;
#(
  parameter int UA_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  seq_t            seq,
  input  logic [UA_W-1:0] disp1,
  input  logic [UA_W-1:0] disp2,
  output logic [UA_W-1:0] upc_nxt
);
  logic [UA_W-1:0] upc_q;
  logic [UA_W-1:0] upc_inc;

  assign upc_inc = upc_q + UA_W'(1);

  always_comb begin
    if (rst) begin
      upc_nxt = UA_W'(UA_FETCH);
    end else begin
      case (seq)
        SEQ_DISP1: upc_nxt = disp1;
        SEQ_DISP2: upc_nxt = disp2;
        SEQ_NEXT:  upc_nxt = upc_inc;
        default:   upc_nxt = UA_W'(UA_FETCH);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    upc_q <= upc_nxt;
  end

  // R7: a terminal word brings the micro-address back to fetch
  p_restart_r7: assert property (@(posedge clk) disable iff (rst)
    (seq == SEQ_FETCH) |=> (upc_q == UA_W'(UA_FETCH)));

  // R6: sequential words step the micro-address by one
  p_step_r6: assert property (@(posedge clk) disable iff (rst)
    (seq == SEQ_NEXT) |=> (upc_q == $past(upc_q) + UA_W'(1)));

  // R8: the micro-address never leaves the programmed range
  p_in_range_r8: assert property (@(posedge clk) disable iff (rst)
    (upc_q < UA_W'(UA_USED)));
endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
  import ucode_pkg::*;
#(
  parameter int OPC_W = 6,
  parameter int UA_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  output logic             pc_wr,
  output logic             pc_wr_cond,
  output logic [1:0]       pc_src,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             addr_data,
  output logic             ir_wr,
  output logic             alu_a_sel,
  output logic [1:0]       alu_b_sel,
  output logic [1:0]       alu_op,
  output logic             rf_wr,
  output logic             rf_dst_rd,
  output logic             wb_from_mem
);
  logic [UA_W-1:0] disp1, disp2, upc_nxt;
  uword_t          word_q;

  ucode_dispatch #(.OPC_W(OPC_W), .UA_W(UA_W)) u_disp (
    .opcode (opcode),
    .disp1  (disp1),
    .disp2  (disp2)
  );

  ucode_next #(.UA_W(UA_W)) u_next (
    .clk     (clk),
    .rst     (rst),
    .seq     (word_q.seq),
    .disp1   (disp1),
    .disp2   (disp2),
    .upc_nxt (upc_nxt)
  );

  ucode_rom #(.UA_W(UA_W)) u_rom (
    .clk     (clk),
    .rd_addr (upc_nxt),
    .word_q  (word_q)
  );

  assign pc_wr       = word_q.ctrl.pc_wr;
  assign pc_wr_cond  = word_q.ctrl.pc_wr_cond;
  assign pc_src      = word_q.ctrl.pc_src;
  assign mem_rd      = word_q.ctrl.mem_rd;
  assign mem_wr      = word_q.ctrl.mem_wr;
  assign addr_data   = word_q.ctrl.addr_data;
  assign ir_wr       = word_q.ctrl.ir_wr;
  assign alu_a_sel   = word_q.ctrl.alu_a_sel;
  assign alu_b_sel   = word_q.ctrl.alu_b_sel;
  assign alu_op      = word_q.ctrl.alu_op;
  assign rf_wr       = word_q.ctrl.rf_wr;
  assign rf_dst_rd   = word_q.ctrl.rf_dst_rd;
  assign wb_from_mem = word_q.ctrl.wb_from_mem;

  // R1: the first cycle out of reset carries the fetch word
  p_fetch_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (ir_wr && mem_rd && pc_wr));

  // R9: no simultaneous memory read and write
  p_mem_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  // R9: no simultaneous unconditional and conditional PC write
  p_pc_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    !(pc_wr && pc_wr_cond));

  // R4: a jump opcode at decode leads to the jump word
  p_jump_dispatch_r4: assert property (@(posedge clk) disable iff (rst)
    (word_q.seq == SEQ_DISP1 && opcode == OPC_W'(OP_JUMP))
      |=> (pc_wr && pc_src == 2'b10));
endmodule

// File: tb/ucode_sequencer_test.sv
`timescale 1ns/1ps
module ucode_sequencer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'h00;
  logic       pc_wr, pc_wr_cond, mem_rd, mem_wr, addr_data, ir_wr;
  logic       alu_a_sel, rf_wr, rf_dst_rd, wb_from_mem;
  logic [1:0] pc_src, alu_b_sel, alu_op;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  ucode_sequencer uut (
    .clk(clk), .rst(rst), .opcode(opcode),
    .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .pc_src(pc_src),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .addr_data(addr_data), .ir_wr(ir_wr),
    .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_op(alu_op),
    .rf_wr(rf_wr), .rf_dst_rd(rf_dst_rd), .wb_from_mem(wb_from_mem)
  );

  wire [15:0] got = {pc_wr, pc_wr_cond, pc_src, mem_rd, mem_wr, addr_data, ir_wr,
                     alu_a_sel, alu_b_sel, alu_op, rf_wr, rf_dst_rd, wb_from_mem};

  // Reference states: 0 fetch, 1 decode, 2 address, 3 mem read, 4 load wb,
  // 5 mem write, 6 execute, 7 reg wb, 8 branch, 9 jump.
  function automatic logic [15:0] exp_ctrl(input int s);
    case (s)
      0: return 16'b1_0_00_1_0_0_1_0_01_00_0_0_0;
      1: return 16'b0_0_00_0_0_0_0_0_11_00_0_0_0;
      2: return 16'b0_0_00_0_0_0_0_1_10_00_0_0_0;
      3: return 16'b0_0_00_1_0_1_0_0_00_00_0_0_0;
      4: return 16'b0_0_00_0_0_0_0_0_00_00_1_0_1;
      5: return 16'b0_0_00_0_1_1_0_0_00_00_0_0_0;
      6: return 16'b0_0_00_0_0_0_0_1_00_10_0_0_0;
      7: return 16'b0_0_00_0_0_0_0_0_00_00_1_1_0;
      8: return 16'b0_1_01_0_0_0_0_1_00_01_0_0_0;
      default: return 16'b1_0_10_0_0_0_0_0_00_00_0_0_0;
    endcase
  endfunction

  function automatic int nxt_state(input int s, input logic [5:0] op);
    case (s)
      0: return 1;
      1: case (op)
           6'h00: return 6;
           6'h23, 6'h2B: return 2;
           6'h04: return 8;
           6'h02: return 9;
           default: return 0;
         endcase
      2: return (op == 6'h23) ? 3 : 5;
      3: return 4;
      6: return 7;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_len(input logic [5:0] op);
    case (op)
      6'h23: return 5;
      6'h2B, 6'h00: return 4;
      6'h04, 6'h02: return 3;
      default: return 2;
    endcase
  endfunction

  function automatic string content_tag(input int s);
    if (s == 0) return "R2";
    if (s == 1) return "R3";
    return "R10";
  endfunction

  function automatic string arrive_tag(input int from, input int to);
    if (from == 1 && to == 0) return "R8";
    if (from == 1) return "R4";
    if (from == 2) return "R5";
    if (from == 0 || from == 3 || from == 6) return "R6";
    return "R7";
  endfunction

  task automatic check(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  // Called on a falling edge with the design in fetch; runs one instruction.
  task automatic run_instr(input logic [5:0] op, input string entry_tag);
    int    s   = 0;
    int    len = 0;
    string tag = entry_tag;
    opcode = op;
    do begin
      int ns;
      check(got === exp_ctrl(s), {content_tag(s), "/", tag}, got, exp_ctrl(s));
      check(!(mem_rd && mem_wr) && !(pc_wr && pc_wr_cond), "R9", got, 16'h0);
      len++;
      ns  = nxt_state(s, op);
      tag = arrive_tag(s, ns);
      @(negedge clk);
      s = ns;
    end while (s != 0);
    check(len == exp_len(op), (exp_len(op) == 2) ? "R8" : "R7",
          16'(len), 16'(exp_len(op)));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(got === exp_ctrl(0), "R1 in reset", got, exp_ctrl(0));
    rst = 1'b0;
    run_instr(6'h23, "R1");
    for (int i = 0; i < 64; i++) run_instr(6'(i), "R7");
    for (int i = 63; i >= 0; i--) run_instr(6'(i), "R7");
    run_instr(6'h04, "R7");
    run_instr(6'h02, "R7");
    run_instr(6'h2B, "R7");
    run_instr(6'h00, "R7");
    run_instr(6'h3F, "R7");
    run_instr(6'h23, "R7");
    // Reset in the middle of a load: expect the fetch word right away.
    opcode = 6'h23;
    repeat (3) @(negedge clk);
    check(got === exp_ctrl(3), "R10", got, exp_ctrl(3));
    rst = 1'b1;
    @(negedge clk);
    check(got === exp_ctrl(0), "R1 mid-run", got, exp_ctrl(0));
    rst = 1'b0;
    run_instr(6'h2B, "R1");
    run_instr(6'h04, "R7");
    done = 1'b1;
    summary();
    $finish;
  end
endmodule